// File: doc/BRIEF.md
# Programmable Domain Clock Divider

This block derives one domain clock from a reference clock by an integer ratio that can be reprogrammed at run time. The reference may be a PLL output or the board oscillator itself. A new ratio presented on the ratio input is only captured when the update strobe is pulsed. It then takes effect at the next boundary between output periods, so the domain never sees a shortened or stretched cycle. A lock flag drops on the strobe and comes back once a whole output period has run at the new ratio.

The same unit gates the domain clock with an enable input, without producing runt pulses. It also produces the domain's reset output: the reset asserts at once from a domain reset request and is released in step with a rising edge of the divided clock. Two parameters let an instance be built without the enable, without ratio programming, or without either. Inputs that belong to a removed feature are then ignored.

Top module: `clkdiv_domain`

## Requirements
- R1: After power-on reset the divider runs at the parameter `DEFAULT_RATIO`, and `lock_o` rises within 2*DEFAULT_RATIO+3 reference cycles of reset release. `lock_o` is low and `rst_o` is high while the power-on reset is active.
- R2: A value on `ratio_i` without an `update_i` strobe does not change the output period and does not drop `lock_o`.
- R3: The `update_i` strobe captures `ratio_i`, and `lock_o` is low in the cycle after the strobe. The new ratio starts at the next output period boundary. `lock_o` rises after one full period at the new ratio, i.e. 1+N to old+N+1 cycles after the strobe, where ratios 0 and 1 count as 1.
- R4: For a ratio N of 2 or more, the output period is N reference cycles and the high phase is floor(N/2) cycles.
- R5: Ratios 0 and 1 pass the reference clock to `div_clk_o` undivided: the output is high in the high half of the reference clock and low in its low half.
- R6: With `en_i` low, `div_clk_o` is held low. The enable change applies only while the divided clock is low, so every high pulse that appears has its full length.
- R7: `rst_o` is high whenever `rst_dom_i` is high, within the same cycle and without waiting for a clock edge.
- R8: After `rst_dom_i` falls, `rst_o` falls on the second rising edge of the divided clock, at the same reference edge as that rising edge.
- R9: With `USE_ENABLE` = 0, `en_i` has no effect and the divided clock always runs.
- R10: With `USE_RATIO` = 0, `ratio_i` and `update_i` have no effect: the instance keeps `DEFAULT_RATIO` and `lock_o` stays high after the initial lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock to be divided |
| rst_i | input | 1 | Power-on reset, asynchronous, active high |
| ratio_i | input | RATIO_W | Requested divide ratio, captured on update |
| update_i | input | 1 | Strobe that applies the requested ratio |
| en_i | input | 1 | Domain clock enable |
| rst_dom_i | input | 1 | Domain reset request, active high |
| div_clk_o | output | 1 | Divided, gated domain clock |
| lock_o | output | 1 | High while the output runs stably at the active ratio |
| rst_o | output | 1 | Domain reset, released on a divided clock rising edge |

## Verification
Two situations are hard to reach from the ports: a ratio change that lands at a period boundary, and an enable change made in the middle of a high phase. The bench reaches the first by chaining updates whose old and new ratios differ (6, 3, 2, 7, bypass, 0, 5, 4), and it bounds the lock latency by both ratios. It reaches the second by following the output sample by sample, dropping the enable on the exact cycle a high phase begins, and checking that the pulse still completes. The reset release is tracked by counting divided rising edges until `rst_o` falls.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Progress of the divider toward a stable output at the active ratio.
    typedef enum logic [1:0] {
        LK_WAIT   = 2'd0,  // ratio captured, waiting for a period boundary
        LK_SETTLE = 2'd1,  // new ratio running, first full period in progress
        LK_LOCKED = 2'd2   // output stable
    } lock_st_e;

    // Stages between domain reset removal and reset output release.
    localparam int RST_SYNC_STAGES = 2;

endpackage

// File: rtl/clkdiv_ratio_ctrl.sv
module clkdiv_ratio_ctrl
    import clkdiv_pkg::*;
#(
    parameter int RATIO_W       = 8,
    parameter int DEFAULT_RATIO = 4,
    parameter int USE_RATIO     = 1
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               update_i,
    input  logic               tick_i,
    output logic [RATIO_W-1:0] act_q_o,
    output logic [RATIO_W-1:0] act_d_o,
    output logic               lock_o
);

    localparam logic [RATIO_W-1:0] DEF_RATIO = RATIO_W'(DEFAULT_RATIO);

    typedef struct packed {
        lock_st_e           st;
        logic [RATIO_W-1:0] pend;
        logic [RATIO_W-1:0] act;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  upd_d;

    always_comb begin
        upd_d = (USE_RATIO != 0) && update_i;
        c_d   = c_q;
        if (upd_d) begin
            // A fresh strobe restarts the handshake, even mid-sequence.
            c_d.pend = ratio_i;
            c_d.st   = LK_WAIT;
        end else if (tick_i) begin
            case (c_q.st)
                LK_WAIT: begin
                    c_d.act = c_q.pend;
                    c_d.st  = LK_SETTLE;
                end
                LK_SETTLE: c_d.st = LK_LOCKED;
                default:   c_d.st = c_q.st;
            endcase
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            c_q <= '{st: LK_WAIT, pend: DEF_RATIO, act: DEF_RATIO};
        end else begin
            c_q <= c_d;
        end
    end

    assign act_q_o = c_q.act;
    assign act_d_o = c_d.act;
    assign lock_o  = (c_q.st == LK_LOCKED);

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
    parameter int RATIO_W = 8
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [RATIO_W-1:0] ratio_q_i,
    input  logic [RATIO_W-1:0] ratio_d_i,
    output logic               tick_o,
    output logic               hi_q_o,
    output logic               hi_d_o,
    output logic               byp_o
);

    localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic               hi;
        logic               byp;
    } cnt_t;

    cnt_t s_d, s_q;
    logic tick_d;

    // Ratios 0 and 1 both behave as a single-cycle period.
    function automatic logic [RATIO_W-1:0] eff_ratio(input logic [RATIO_W-1:0] r);
        return (r <= ONE) ? ONE : r;
    endfunction

    // Period boundary: this cycle ends the current output period.
    always_comb begin
        tick_d = (s_q.cnt >= (eff_ratio(ratio_q_i) - ONE));
    end

    always_comb begin
        s_d.cnt = tick_d ? '0 : (s_q.cnt + ONE);
        s_d.hi  = (s_d.cnt < (eff_ratio(ratio_d_i) >> 1));
        s_d.byp = (ratio_d_i <= ONE);
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            // All ones forces a boundary on the first edge after reset.
            s_q <= '{cnt: '1, hi: 1'b0, byp: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign tick_o = tick_d;
    assign hi_q_o = s_q.hi;
    assign hi_d_o = s_d.hi;
    assign byp_o  = s_q.byp;

endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate #(
    parameter int USE_ENABLE = 1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic hi_q_i,
    input  logic hi_d_i,
    input  logic byp_i,
    output logic div_clk_o,
    output logic gate_o
);

    logic en_eff;
    logic gate_d, gate_q;
    logic gate_n_q;

    always_comb begin
        en_eff = (USE_ENABLE != 0) ? en_i : 1'b1;
        // Only follow the enable on edges after which the output is low.
        gate_d = hi_d_i ? gate_q : en_eff;
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= gate_d;
        end
    end

    // Pass-through path: sample the enable while the reference is low.
    always_ff @(negedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            gate_n_q <= 1'b0;
        end else begin
            gate_n_q <= en_eff;
        end
    end

    assign div_clk_o = byp_i ? (clk_i & gate_n_q) : (hi_q_i & gate_q);
    assign gate_o    = gate_q;

endmodule

// File: rtl/clkdiv_rst_out.sv
module clkdiv_rst_out #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic rst_dom_i,
    input  logic tick_i,
    output logic rst_o
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        if (rst_dom_i) begin
            sh_d = '1;
        end else if (tick_i) begin
            // Advance only on a divided-clock rising edge.
            sh_d = sh_q << 1;
        end else begin
            sh_d = sh_q;
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            sh_q <= '1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign rst_o = rst_dom_i | sh_q[STAGES-1];

endmodule

// File: rtl/clkdiv_domain.sv
module clkdiv_domain
    import clkdiv_pkg::*;
#(
    parameter int RATIO_W       = 8,
    parameter int DEFAULT_RATIO = 4,
    parameter int USE_ENABLE    = 1,
    parameter int USE_RATIO     = 1
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               update_i,
    input  logic               en_i,
    input  logic               rst_dom_i,
    output logic               div_clk_o,
    output logic               lock_o,
    output logic               rst_o
);

    logic [RATIO_W-1:0] act_q_w;
    logic [RATIO_W-1:0] act_d_w;
    logic               tick_w;
    logic               hi_q_w;
    logic               hi_d_w;
    logic               byp_w;
    logic               gate_w;

    clkdiv_ratio_ctrl #(
        .RATIO_W      (RATIO_W),
        .DEFAULT_RATIO(DEFAULT_RATIO),
        .USE_RATIO    (USE_RATIO)
    ) u_ctrl (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .ratio_i (ratio_i),
        .update_i(update_i),
        .tick_i  (tick_w),
        .act_q_o (act_q_w),
        .act_d_o (act_d_w),
        .lock_o  (lock_o)
    );

    clkdiv_counter #(
        .RATIO_W(RATIO_W)
    ) u_cnt (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .ratio_q_i(act_q_w),
        .ratio_d_i(act_d_w),
        .tick_o   (tick_w),
        .hi_q_o   (hi_q_w),
        .hi_d_o   (hi_d_w),
        .byp_o    (byp_w)
    );

    clkdiv_gate #(
        .USE_ENABLE(USE_ENABLE)
    ) u_gate (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .en_i     (en_i),
        .hi_q_i   (hi_q_w),
        .hi_d_i   (hi_d_w),
        .byp_i    (byp_w),
        .div_clk_o(div_clk_o),
        .gate_o   (gate_w)
    );

    clkdiv_rst_out #(
        .STAGES(RST_SYNC_STAGES)
    ) u_rst (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .rst_dom_i(rst_dom_i),
        .tick_i   (tick_w),
        .rst_o    (rst_o)
    );

endmodule

// File: rtl/clkdiv_domain_chk.sv
module clkdiv_domain_chk #(
    parameter int RATIO_W   = 8,
    parameter int USE_RATIO = 1
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               update_i,
    input logic               rst_dom_i,
    input logic               lock_o,
    input logic               rst_o,
    input logic               tick,
    input logic               hi_q,
    input logic               byp,
    input logic               gate,
    input logic [RATIO_W-1:0] act
);

    // R3: lock drops right after an accepted update strobe
    p_lock_drop_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (update_i && (USE_RATIO != 0)) |=> !lock_o);

    // R3: lock only returns at the end of an output period
    p_lock_rise_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(lock_o) |-> $past(tick));

    // R2: the active ratio only moves at a period boundary
    p_ratio_boundary_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(act) |-> $past(tick));

    // R6: the gate never changes while the divided clock is high
    p_gate_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!byp && hi_q) |-> $stable(gate));

    // R7: domain reset request forces the reset output
    p_rst_follow_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        rst_dom_i |-> rst_o);

    // R8: reset output is released on a divided clock rising edge
    p_rst_release_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(rst_o) && !byp) |-> (hi_q && !$past(hi_q)));

endmodule

bind clkdiv_domain clkdiv_domain_chk #(
    .RATIO_W  (RATIO_W),
    .USE_RATIO(USE_RATIO)
) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .update_i (update_i),
    .rst_dom_i(rst_dom_i),
    .lock_o   (lock_o),
    .rst_o    (rst_o),
    .tick     (tick_w),
    .hi_q     (hi_q_w),
    .byp      (byp_w),
    .gate     (gate_w),
    .act      (act_q_w)
);

// File: tb/sim_clkdiv_domain.sv
module sim_clkdiv_domain;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int RW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [RW-1:0] ratio0 = 8'd4;
    logic [RW-1:0] ratio1 = 8'd3;
    logic          upd0 = 1'b0, upd1 = 1'b0;
    logic          en0 = 1'b1, en1 = 1'b1;
    logic          rdom0 = 1'b0, rdom1 = 1'b0;
    logic          div0, lock0, ro0;
    logic          div1, lock1, ro1;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    clkdiv_domain #(.RATIO_W(RW), .DEFAULT_RATIO(4)) u0 (
        .clk_i(clk), .rst_i(rst), .ratio_i(ratio0), .update_i(upd0), .en_i(en0),
        .rst_dom_i(rdom0), .div_clk_o(div0), .lock_o(lock0), .rst_o(ro0)
    );

    clkdiv_domain #(.RATIO_W(RW), .DEFAULT_RATIO(3), .USE_ENABLE(0), .USE_RATIO(0)) u1 (
        .clk_i(clk), .rst_i(rst), .ratio_i(ratio1), .update_i(upd1), .en_i(en1),
        .rst_dom_i(rdom1), .div_clk_o(div1), .lock_o(lock1), .rst_o(ro1)
    );

    task automatic chk_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic dv(input int s);
        return (s != 0) ? div1 : div0;
    endfunction

    // Period and high-phase length of one divided cycle, in reference cycles.
    task automatic measure(input int s, output int per, output int hi);
        logic prev;
        int   guard;
        prev  = dv(s);
        step();
        guard = 0;
        while (!(prev == 1'b0 && dv(s) == 1'b1) && guard < 300) begin
            prev = dv(s);
            step();
            guard++;
        end
        per = 0;
        hi  = 0;
        do begin
            if (dv(s)) hi++;
            per++;
            prev = dv(s);
            step();
        end while (!(prev == 1'b0 && dv(s) == 1'b1) && per < 300);
    endtask

    task automatic wait_lock0(output int cyc);
        cyc = 0;
        while (!lock0 && cyc < 600) begin
            step();
            cyc++;
        end
    endtask

    task automatic t_reset();
        int cyc, per, hi;
        repeat (3) step();
        chk_eq("R1 lock low in reset", lock0, 0);
        chk_eq("R1 rst_o high in reset", ro0, 1);
        rst = 1'b0;
        wait_lock0(cyc);
        chk_rng("R1 lock after reset", cyc, 4, 11);
        measure(0, per, hi);
        chk_eq("R1 default period", per, 4);
        chk_eq("R4 default high phase", hi, 2);
    endtask

    task automatic t_no_update();
        int per, hi, drops;
        ratio0 = 8'd6;
        drops  = 0;
        repeat (40) begin
            step();
            if (!lock0) drops++;
        end
        chk_eq("R2 lock kept without update", drops, 0);
        measure(0, per, hi);
        chk_eq("R2 period unchanged without update", per, 4);
    endtask

    task automatic t_update(input int n, input int old_eff);
        int cyc, per, hi, n_eff;
        n_eff  = (n <= 1) ? 1 : n;
        ratio0 = RW'(n);
        upd0   = 1'b1;
        step();
        upd0 = 1'b0;
        chk_eq("R3 lock low after update", lock0, 0);
        wait_lock0(cyc);
        chk_rng("R3 relock latency", cyc, n_eff + 1, old_eff + n_eff + 1);
        if (n >= 2) begin
            measure(0, per, hi);
            chk_eq("R4 period", per, n);
            chk_eq("R4 high phase", hi, n / 2);
        end
    endtask

    task automatic t_bypass(input string tag);
        repeat (4) begin
            step();
            chk_eq({"R5 pass-through high half ", tag}, div0, 1);
            #2;
            chk_eq({"R5 pass-through low half ", tag}, div0, 0);
        end
    endtask

    task automatic t_enable();
        logic prev;
        int   run, highs, per, hi, guard;
        prev  = div0;
        step();
        guard = 0;
        while (!(prev == 1'b0 && div0 == 1'b1) && guard < 50) begin
            prev = div0;
            step();
            guard++;
        end
        en0 = 1'b0;
        run = 1;
        step();
        while (div0 && run < 20) begin
            run++;
            step();
        end
        chk_eq("R6 pulse completes after disable", run, 2);
        highs = 0;
        repeat (24) begin
            step();
            if (div0) highs++;
        end
        chk_eq("R6 output held low when disabled", highs, 0);
        en0 = 1'b1;
        measure(0, per, hi);
        chk_eq("R6 first pulse after enable full", hi, 2);
        chk_eq("R6 period after enable", per, 4);
    endtask

    task automatic t_dom_reset();
        logic prev;
        int   rises, guard, rose_at_fall;
        rdom0 = 1'b1;
        #0.5;
        chk_eq("R7 rst_o follows request at once", ro0, 1);
        repeat (5) step();
        chk_eq("R7 rst_o held during request", ro0, 1);
        rdom0        = 1'b0;
        prev         = div0;
        rises        = 0;
        rose_at_fall = 0;
        guard        = 0;
        while (ro0 && guard < 60) begin
            step();
            if (prev == 1'b0 && div0 == 1'b1) rises++;
            if (!ro0) rose_at_fall = (prev == 1'b0 && div0 == 1'b1) ? 1 : 0;
            prev = div0;
            guard++;
        end
        chk_eq("R8 rst_o released", ro0, 0);
        chk_eq("R8 release on second rising edge", rises, 2);
        chk_eq("R8 release coincides with rising edge", rose_at_fall, 1);
    endtask

    task automatic t_stripped();
        int per, hi;
        en1    = 1'b0;
        ratio1 = 8'd6;
        upd1   = 1'b1;
        step();
        upd1 = 1'b0;
        chk_eq("R10 lock ignores update", lock1, 1);
        repeat (20) step();
        measure(1, per, hi);
        chk_eq("R9 enable ignored, high phase", hi, 1);
        chk_eq("R10 ratio ignored, period", per, 3);
        chk_eq("R10 lock stays high", lock1, 1);
    endtask

    initial begin
        t_reset();
        t_no_update();
        t_update(6, 4);
        t_update(3, 6);
        t_update(2, 3);
        t_update(7, 2);
        t_update(1, 7);
        t_bypass("ratio 1");
        t_update(0, 1);
        t_bypass("ratio 0");
        t_update(5, 1);
        t_update(4, 5);
        t_enable();
        t_dom_reset();
        t_stripped();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule